// File: doc/BRIEF.md
# Branch Target Generator

This unit resolves the control-transfer step of an 8-bit accumulator microcontroller. The decoder supplies a branch kind, the address and length of the current instruction, its operand bytes, and the data values that a condition may need: the accumulator, the 16-bit data pointer, the carry flag, a tested bit and two compare bytes. One cycle after a start strobe, the unit returns the next program counter and a taken flag. It also returns any write-back the instruction implies: a carry update for compare, a decremented byte for decrement-and-test, or a clear of the tested bit.

Four target formats are supported. The relative format adds a signed byte to the advanced PC. The in-page format keeps the top 5 bits of the advanced PC and substitutes an 11-bit field. The long format loads a full 16-bit address. The indexed format adds the accumulator to the data pointer. Every sum wraps at 65536. The advanced PC is the current address plus the instruction length.

A two-state controller sequences the unit. In `ST_IDLE`, a start moves it to `ST_DONE` and loads the result registers. In `ST_DONE`, the unit raises `done`. Another start there stays in `ST_DONE` and loads a new result. Without a start, `ST_DONE` returns to `ST_IDLE`. The result registers hold their values until the next start.

Top module: `branch_target_gen`

## Requirements
- R1: `done` is high in exactly the cycle after each cycle in which `start` is high. Results load on that start and are held until the next start. Reset clears every output to 0.
- R2: When no branch is taken, `next_pc` = `cur_pc` + `ins_len`, modulo 65536. Kind 0 is plain sequential flow and is never taken.
- R3: Kind 1 (short relative) is always taken, with `next_pc` = `cur_pc` + `ins_len` + sign-extended `rel_ofs`, modulo 65536.
- R4: Kind 2 (in-page) is always taken. Its `next_pc` takes bits 15..11 from `cur_pc` + `ins_len` and bits 10..0 from {`op_hi`[2:0], `op_lo`}.
- R5: Kind 3 (long) is always taken, with `next_pc` = {`op_hi`, `op_lo`}.
- R6: Kind 4 (indexed) is always taken, with `next_pc` = `dptr` + zero-extended `acc`, modulo 65536.
- R7: Kind 5 is taken when `acc` is 00h, and kind 6 is taken when `acc` is non-zero. The target is relative, as in R3.
- R8: Kinds 7 and 8 are taken when `cy_in` is 1 and 0 respectively. Kinds 9 and 10 are taken when `bit_in` is 1 and 0 respectively. The target is relative.
- R9: Kind 11 is taken with `bit_clr` = 1 only when `bit_in` is 1. When `bit_in` is 0 it falls through with `bit_clr` = 0.
- R10: Kind 12 is taken when `opd_a` differs from `opd_b`. It always sets `cy_we` = 1, with `cy_out` = 1 exactly when `opd_a` < `opd_b` as unsigned values.
- R11: Kind 13 sets `byte_we` = 1 and `byte_out` = `opd_a` - 1, so that 00h wraps to FFh. It is taken only when `byte_out` is non-zero.
- R12: Kinds 14 and 15 fall through, with `taken` = 0 and no write-back enable.
- R13: `cy_we` is raised only for kind 12, `byte_we` only for kind 13, and `bit_clr` only for kind 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the presented instruction |
| br_type | input | 4 | Branch kind code (0..15) |
| cur_pc | input | 16 | Address of the current instruction |
| ins_len | input | 2 | Instruction length in bytes (1..3) |
| op_hi | input | 8 | High address operand byte |
| op_lo | input | 8 | Low address operand byte |
| rel_ofs | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the tested bit |
| opd_a | input | 8 | Compare destination byte or decrement operand |
| opd_b | input | 8 | Compare source byte |
| done | output | 1 | Result valid strobe |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |
| cy_we | output | 1 | Carry write enable |
| cy_out | output | 1 | New carry value |
| byte_we | output | 1 | Decremented byte write enable |
| byte_out | output | 8 | Decremented byte |
| bit_clr | output | 1 | Clear the tested bit |

## Verification
Relative offsets are tried at +30, -128, +127 and -2. Together these separate sign extension from zero extension, and a base of PC+2 from one of PC+0. One in-page case advances across a 2 KB boundary, which shows that the kept upper bits come from the advanced PC and not from the raw address. Indexed and wrapping cases carry out of bit 15, which exposes any arithmetic narrower or wider than 16 bits. Each condition is driven both true and false, and the compare is driven with less-than, equal and greater-than operands. Decrement is tried at 01h and 00h, which tells the zero test on the new value apart from a test on the old one. Unknown kinds are presented with every condition input set, so that any stray write enable shows up.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        BR_SEQ   = 4'd0,
        BR_SREL  = 4'd1,
        BR_PAGE  = 4'd2,
        BR_LONG  = 4'd3,
        BR_INDEX = 4'd4,
        BR_AZERO = 4'd5,
        BR_ANZ   = 4'd6,
        BR_CSET  = 4'd7,
        BR_CCLR  = 4'd8,
        BR_BSET  = 4'd9,
        BR_BCLR  = 4'd10,
        BR_BTAC  = 4'd11,
        BR_CMPNE = 4'd12,
        BR_DECNZ = 4'd13
    } br_kind_e;

    typedef enum logic [2:0] {
        TGT_SEQ,
        TGT_REL,
        TGT_PAGE,
        TGT_LONG,
        TGT_INDEX
    } tgt_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } fsm_e;

endpackage

// File: rtl/brtgt_target.sv
module brtgt_target
    import brtgt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  tgt_sel_e          sel,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [1:0]        ins_len,
    input  logic [DW-1:0]     op_hi,
    input  logic [DW-1:0]     op_lo,
    input  logic [DW-1:0]     rel_ofs,
    input  logic [DW-1:0]     acc,
    input  logic [PC_W-1:0]   dptr,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   tgt_pc
);

    localparam int EXT_W = PC_W - DW;

    logic [PC_W-1:0] rel_ext;
    logic [PC_W-1:0] long_addr;
    logic [PC_W-1:0] acc_ext;

    always_comb begin
        seq_pc    = cur_pc + PC_W'(ins_len);
        rel_ext   = {{EXT_W{rel_ofs[DW-1]}}, rel_ofs};
        long_addr = PC_W'({op_hi, op_lo});
        acc_ext   = {{EXT_W{1'b0}}, acc};
    end

    always_comb begin
        unique case (sel)
            TGT_REL:   tgt_pc = seq_pc + rel_ext;
            TGT_PAGE:  tgt_pc = {seq_pc[PC_W-1:PAGE_W], long_addr[PAGE_W-1:0]};
            TGT_LONG:  tgt_pc = long_addr;
            TGT_INDEX: tgt_pc = dptr + acc_ext;
            default:   tgt_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/brtgt_cond.sv
module brtgt_cond
    import brtgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  br_kind_e          kind,
    input  logic [DW-1:0]     acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DW-1:0]     opd_a,
    input  logic [DW-1:0]     opd_b,
    output logic              take,
    output tgt_sel_e          sel,
    output logic              cy_we,
    output logic              cy_val,
    output logic              byte_we,
    output logic [DW-1:0]     byte_val,
    output logic              bit_clr
);

    logic          acc_zero;
    logic [DW-1:0] dec_val;

    always_comb begin
        acc_zero = (acc == '0);
        dec_val  = opd_a - DW'(1);
    end

    always_comb begin
        take     = 1'b0;
        sel      = TGT_SEQ;
        cy_we    = 1'b0;
        cy_val   = 1'b0;
        byte_we  = 1'b0;
        byte_val = dec_val;
        bit_clr  = 1'b0;
        unique case (kind)
            BR_SEQ: begin
                take = 1'b0;
            end
            BR_SREL: begin
                take = 1'b1;
                sel  = TGT_REL;
            end
            BR_PAGE: begin
                take = 1'b1;
                sel  = TGT_PAGE;
            end
            BR_LONG: begin
                take = 1'b1;
                sel  = TGT_LONG;
            end
            BR_INDEX: begin
                take = 1'b1;
                sel  = TGT_INDEX;
            end
            BR_AZERO: begin
                take = acc_zero;
                sel  = TGT_REL;
            end
            BR_ANZ: begin
                take = !acc_zero;
                sel  = TGT_REL;
            end
            BR_CSET: begin
                take = cy_in;
                sel  = TGT_REL;
            end
            BR_CCLR: begin
                take = !cy_in;
                sel  = TGT_REL;
            end
            BR_BSET: begin
                take = bit_in;
                sel  = TGT_REL;
            end
            BR_BCLR: begin
                take = !bit_in;
                sel  = TGT_REL;
            end
            BR_BTAC: begin
                take    = bit_in;
                bit_clr = bit_in;
                sel     = TGT_REL;
            end
            BR_CMPNE: begin
                take   = (opd_a != opd_b);
                cy_we  = 1'b1;
                cy_val = (opd_a < opd_b);
                sel    = TGT_REL;
            end
            BR_DECNZ: begin
                take    = (dec_val != '0);
                byte_we = 1'b1;
                sel     = TGT_REL;
            end
            default: begin
                take = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import brtgt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        br_type,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [1:0]        ins_len,
    input  logic [DW-1:0]     op_hi,
    input  logic [DW-1:0]     op_lo,
    input  logic [DW-1:0]     rel_ofs,
    input  logic [DW-1:0]     acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DW-1:0]     opd_a,
    input  logic [DW-1:0]     opd_b,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              cy_we,
    output logic              cy_out,
    output logic              byte_we,
    output logic [DW-1:0]     byte_out,
    output logic              bit_clr
);

    fsm_e            state_q;
    fsm_e            state_d;
    br_kind_e        kind;
    tgt_sel_e        sel;
    logic            take_c;
    logic            cy_we_c;
    logic            cy_val_c;
    logic            byte_we_c;
    logic [DW-1:0]   byte_val_c;
    logic            bit_clr_c;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] tgt_pc;
    logic [PC_W-1:0] pc_c;

    assign kind = br_kind_e'(br_type);

    brtgt_cond #(.DW(DW)) u_cond (
        .kind     (kind),
        .acc      (acc),
        .cy_in    (cy_in),
        .bit_in   (bit_in),
        .opd_a    (opd_a),
        .opd_b    (opd_b),
        .take     (take_c),
        .sel      (sel),
        .cy_we    (cy_we_c),
        .cy_val   (cy_val_c),
        .byte_we  (byte_we_c),
        .byte_val (byte_val_c),
        .bit_clr  (bit_clr_c)
    );

    brtgt_target #(.PC_W(PC_W), .DW(DW), .PAGE_W(PAGE_W)) u_target (
        .sel     (sel),
        .cur_pc  (cur_pc),
        .ins_len (ins_len),
        .op_hi   (op_hi),
        .op_lo   (op_lo),
        .rel_ofs (rel_ofs),
        .acc     (acc),
        .dptr    (dptr),
        .seq_pc  (seq_pc),
        .tgt_pc  (tgt_pc)
    );

    assign pc_c = take_c ? tgt_pc : seq_pc;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            next_pc  <= '0;
            cy_we    <= 1'b0;
            cy_out   <= 1'b0;
            byte_we  <= 1'b0;
            byte_out <= '0;
            bit_clr  <= 1'b0;
        end else if (start) begin
            taken    <= take_c;
            next_pc  <= pc_c;
            cy_we    <= cy_we_c;
            cy_out   <= cy_val_c;
            byte_we  <= byte_we_c;
            byte_out <= byte_val_c;
            bit_clr  <= bit_clr_c;
        end
    end

    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk #(
    parameter int PC_W = 16,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      br_type,
    input logic [PC_W-1:0] cur_pc,
    input logic [1:0]      ins_len,
    input logic [DW-1:0]   acc,
    input logic [PC_W-1:0] dptr,
    input logic [DW-1:0]   opd_a,
    input logic [DW-1:0]   opd_b,
    input logic            done,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            cy_we,
    input logic            cy_out,
    input logic            byte_we,
    input logic [DW-1:0]   byte_out,
    input logic            bit_clr
);

    // R1
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R1
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    // R2
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !taken |-> next_pc == $past(cur_pc + PC_W'(ins_len)));

    // R6
    index_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && br_type == 4'd4 |=> taken && next_pc == $past(dptr + PC_W'(acc)));

    // R9
    clear_implies_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && bit_clr |-> taken);

    // R10
    compare_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && br_type == 4'd12 |=> cy_we && cy_out == $past(opd_a < opd_b)
                                      && taken == $past(opd_a != opd_b));

    // R11
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && br_type == 4'd13 |=> byte_we && byte_out == $past(DW'(opd_a - DW'(1)))
                                      && taken == (byte_out != '0));

    // R12
    unknown_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && br_type >= 4'd14 |=> !taken && !cy_we && !byte_we && !bit_clr);

    // R13
    single_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({cy_we, byte_we, bit_clr}) <= 1);

endmodule

bind branch_target_gen brtgt_chk #(.PC_W(PC_W), .DW(DW)) i_brtgt_chk (.*);

// File: tb/test_branch_target_gen.sv
module test_branch_target_gen;

    typedef struct packed {
        logic [3:0]  ty;
        logic [15:0] pc;
        logic [1:0]  len;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [7:0]  rel;
        logic [7:0]  acc;
        logic [15:0] dptr;
        logic        cy;
        logic        bt;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] epc;
        logic        etk;
        logic        ecyw;
        logic        ecy;
        logic        ebw;
        logic [7:0]  ebv;
        logic        eclr;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h1234, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h1237, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd1,  16'h0100, 2'd2, 8'h00, 8'h00, 8'h1E, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0120, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd1,  16'h0100, 2'd2, 8'h00, 8'h00, 8'h80, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0082, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd1,  16'hFFFF, 2'd2, 8'h00, 8'h00, 8'h7F, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd2,  16'h07FE, 2'd2, 8'h05, 8'h34, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0D34, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd2,  16'h3000, 2'd2, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h37FF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd3,  16'h0000, 2'd3, 8'hAB, 8'hCD, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd4,  16'h0000, 2'd1, 8'h00, 8'h00, 8'h00, 8'hF0, 16'hFF20, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd4,  16'h5555, 2'd1, 8'h00, 8'h00, 8'h00, 8'h08, 16'h1F00, 1'b0, 1'b0, 8'h00, 8'h00, 16'h1F08, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd5,  16'h0200, 2'd2, 8'h00, 8'h00, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0212, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd5,  16'h0200, 2'd2, 8'h00, 8'h00, 8'h10, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0202, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd6,  16'h0200, 2'd2, 8'h00, 8'h00, 8'hFE, 8'h80, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd6,  16'h0200, 2'd2, 8'h00, 8'h00, 8'hFE, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0202, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd7,  16'h0300, 2'd2, 8'h00, 8'h00, 8'h05, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0307, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd7,  16'h0300, 2'd2, 8'h00, 8'h00, 8'h05, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0302, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd8,  16'h0300, 2'd2, 8'h00, 8'h00, 8'h05, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0307, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd8,  16'h0300, 2'd2, 8'h00, 8'h00, 8'h05, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0302, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd9,  16'h0400, 2'd3, 8'h00, 8'h00, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0413, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd10, 16'h0400, 2'd3, 8'h00, 8'h00, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0403, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd10, 16'h0400, 2'd3, 8'h00, 8'h00, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0413, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd12, 16'h0500, 2'd3, 8'h00, 8'h00, 8'hF0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h10, 8'h20, 16'h04F3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
        '{4'd12, 16'h0500, 2'd3, 8'h00, 8'h00, 8'hF0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h33, 8'h33, 16'h0503, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd12, 16'h0500, 2'd3, 8'h00, 8'h00, 8'hF0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h80, 8'h7F, 16'h04F3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd13, 16'h0600, 2'd2, 8'h00, 8'h00, 8'hFC, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h01, 8'h00, 16'h0602, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},
        '{4'd13, 16'h0600, 2'd2, 8'h00, 8'h00, 8'hFC, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h05FE, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0},
        '{4'd14, 16'hFFFE, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd15, 16'h0010, 2'd2, 8'h12, 8'h34, 8'h10, 8'h00, 16'h4000, 1'b1, 1'b1, 8'h01, 8'h02, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd11, 16'h0700, 2'd3, 8'h00, 8'h00, 8'h20, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 16'h0723, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1},
        '{4'd11, 16'h0700, 2'd3, 8'h00, 8'h00, 8'h20, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0703, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'd9,  16'h0400, 2'd3, 8'h00, 8'h00, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0403, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  br_type = '0;
    logic [15:0] cur_pc = '0;
    logic [1:0]  ins_len = '0;
    logic [7:0]  op_hi = '0;
    logic [7:0]  op_lo = '0;
    logic [7:0]  rel_ofs = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        cy_in = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  opd_a = '0;
    logic [7:0]  opd_b = '0;
    logic        done;
    logic        taken;
    logic [15:0] next_pc;
    logic        cy_we;
    logic        cy_out;
    logic        byte_we;
    logic [7:0]  byte_out;
    logic        bit_clr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    branch_target_gen i_branch_target_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .br_type(br_type),
        .cur_pc(cur_pc), .ins_len(ins_len), .op_hi(op_hi), .op_lo(op_lo),
        .rel_ofs(rel_ofs), .acc(acc), .dptr(dptr), .cy_in(cy_in),
        .bit_in(bit_in), .opd_a(opd_a), .opd_b(opd_b), .done(done),
        .taken(taken), .next_pc(next_pc), .cy_we(cy_we), .cy_out(cy_out),
        .byte_we(byte_we), .byte_out(byte_out), .bit_clr(bit_clr)
    );

    function automatic string req_of(input logic [3:0] ty);
        case (ty)
            4'd0:               return "R2";
            4'd1:               return "R3";
            4'd2:               return "R4";
            4'd3:               return "R5";
            4'd4:               return "R6";
            4'd5, 4'd6:         return "R7";
            4'd7, 4'd8, 4'd9, 4'd10: return "R8";
            4'd11:              return "R9";
            4'd12:              return "R10";
            4'd13:              return "R11";
            default:            return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        br_type = v.ty;  cur_pc = v.pc;   ins_len = v.len;
        op_hi = v.hi;    op_lo = v.lo;    rel_ofs = v.rel;
        acc = v.acc;     dptr = v.dptr;   cy_in = v.cy;
        bit_in = v.bt;   opd_a = v.a;     opd_b = v.b;
    endtask

    task automatic check_result(input vec_t v, input int idx);
        string r;
        r = req_of(v.ty);
        check(r, $sformatf("vec %0d done/taken/next_pc", idx),
              {15'd0, done, taken, next_pc}, {15'd0, 1'b1, v.etk, v.epc});
        // R13: write-back enables and values
        check({r, "/R13"}, $sformatf("vec %0d writebacks", idx),
              {28'd0, cy_we, byte_we, bit_clr, 1'b0},
              {28'd0, v.ecyw, v.ebw, v.eclr, 1'b0});
        if (v.ecyw) check("R10", $sformatf("vec %0d carry", idx), {31'd0, cy_out}, {31'd0, v.ecy});
        if (v.ebw)  check("R11", $sformatf("vec %0d byte", idx), {24'd0, byte_out}, {24'd0, v.ebv});
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset outputs",
              {done, taken, cy_we, cy_out, byte_we, bit_clr, byte_out, next_pc},
              32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", {31'd0, done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check_result(VECS[i], i);
            @(negedge clk);
            // R1: strobe lasts one cycle, result held
            check("R1", $sformatf("vec %0d done drops, pc held", i),
                  {15'd0, done, next_pc}, {15'd0, 1'b0, VECS[i].epc});
        end

        // R1: back-to-back starts stay valid and each loads its own result
        apply(VECS[6]);
        start = 1'b1;
        @(negedge clk);
        check("R1", "back-to-back first", {15'd0, done, next_pc}, {15'd0, 1'b1, 16'hABCD});
        apply(VECS[24]);
        @(negedge clk);
        start = 1'b0;
        check("R1", "back-to-back second", {15'd0, done, next_pc}, {15'd0, 1'b1, 16'h05FE});
        apply(VECS[0]);
        @(negedge clk);
        check("R1", "inputs ignored without start", {14'd0, done, byte_we, next_pc},
              {14'd0, 1'b0, 1'b1, 16'h05FE});

        // R1: reset in mid-hold clears held result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "reset clears held result", {14'd0, taken, byte_we, next_pc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule